// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Flag Unit

This block sits beside a FIFO controller on the write-clock side. It holds two threshold registers, one for almost-empty and one for almost-full. From the occupancy count supplied by the controller it produces two registered warning flags. Almost-empty rises when the stored word count drops to the empty threshold or below. Almost-full rises when the remaining free space drops to the full threshold or below.

The thresholds can be changed at run time by one of two methods. The method is fixed when master reset is applied. In parallel mode, each write-clock edge that has both `ld` and `wr_en` high writes one fragment of the write data bus into a threshold. In serial mode, each edge that has `ser_en` high shifts in one bit from `ser_in`. While master reset is held, the level of `ld` chooses one of two preset values, and both thresholds take that value. A partial reset keeps the thresholds and the mode, and sends the load sequence back to its start.

The load sequencer is a state machine with five states. `LD_AE_LO`, `LD_AE_HI`, `LD_AF_LO` and `LD_AF_HI` are the parallel fragment states. `LD_SERIAL` is the single serial state. Master reset enters `LD_SERIAL` when `ser_mode_sel` is high and enters `LD_AE_LO` when it is low. Each parallel write moves the machine along the chain LD_AE_LO → LD_AE_HI → LD_AF_LO → LD_AF_HI → LD_AE_LO. A partial reset sends any parallel state back to `LD_AE_LO`. `LD_SERIAL` is left only through master reset.

Top module: `pflag_unit`

## Requirements
- R1: On a clock edge with `mst_rst` high, both thresholds load 0x07F if `ld` is low and 0x3FF if `ld` is high.
- R2: The level of `ser_mode_sel` on a master-reset edge selects serial loading (1) or parallel loading (0). The selection holds until the next master reset.
- R3: In parallel mode, each edge with `ld` and `wr_en` high writes the next fragment in this order: empty threshold bits [8:0] from `wdata[8:0]`; empty threshold bits [13:9] from `wdata[4:0]`; full threshold bits [8:0]; full threshold bits [13:9]. After the fourth fragment the order wraps to the first.
- R4: In serial mode, each edge with `ser_en` high takes one bit from `ser_in`. The bits fill empty-threshold bits 0 to 13 first, then full-threshold bits 0 to 13. After 28 bits the order wraps.
- R5: In serial mode, `ld`/`wr_en` do not change the thresholds. In parallel mode, `ser_en`/`ser_in` do not change the thresholds.
- R6: A `part_rst` edge leaves both thresholds and the mode unchanged, performs no load, and restarts the load sequence at its first fragment or bit.
- R7: `almost_empty` is high one edge after an edge where `fill_cnt` ≤ the empty threshold, and low otherwise.
- R8: `almost_full` is high one edge after an edge where 16384 − `fill_cnt` ≤ the full threshold, and low otherwise.
- R9: `push_ok` equals `wr_en` AND NOT `ld` AND NOT `ser_en`, in the same cycle. Normal writes are blocked while a load is in progress.
- R10: After an edge with `mst_rst` high, `almost_empty` is 1 and `almost_full` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| mst_rst | input | 1 | Master reset, synchronous, active high |
| part_rst | input | 1 | Partial reset, synchronous, active high |
| ser_mode_sel | input | 1 | Load method, sampled at master reset (1 = serial) |
| ld | input | 1 | Load strobe; also selects the preset during master reset |
| wr_en | input | 1 | Write enable |
| wdata | input | 9 | Write data bus |
| ser_en | input | 1 | Serial shift enable |
| ser_in | input | 1 | Serial data bit |
| fill_cnt | input | 15 | Stored word count from the FIFO controller (0..16384) |
| almost_empty | output | 1 | Registered almost-empty flag |
| almost_full | output | 1 | Registered almost-full flag |
| push_ok | output | 1 | Qualified FIFO write strobe |

## Verification
A threshold written on edge k first affects the flags computed on edge k+1. Each flag follows `fill_cnt` with a delay of exactly one edge. `push_ok` is combinational and is valid in the same cycle as its inputs. The bench drives inputs on the falling edge. It samples 2–3 ns after the rising edge, once the registers have settled. The reference model advances on the same rising edge as the design, so each comparison sees the value due in that cycle. Each boundary probe sets `fill_cnt`, waits one rising edge, and then reads the flags, so every probe carries the one-edge flag delay.

// File: rtl/pflag_pkg.sv
package pflag_pkg;
    typedef enum logic [2:0] {
        LD_AE_LO  = 3'd0,
        LD_AE_HI  = 3'd1,
        LD_AF_LO  = 3'd2,
        LD_AF_HI  = 3'd3,
        LD_SERIAL = 3'd4
    } ld_state_t;
endpackage

// File: rtl/pflag_seq.sv
module pflag_seq
    import pflag_pkg::*;
#(
    parameter int CNT_W = 14,
    localparam int NBITS = 2 * CNT_W,
    localparam int IDX_W = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             mst_rst,
    input  logic             part_rst,
    input  logic             ser_mode_sel,
    input  logic             ld,
    input  logic             wr_en,
    input  logic             ser_en,
    output ld_state_t        state,
    output logic             par_we,
    output logic             ser_we,
    output logic [IDX_W-1:0] ser_idx
);
    ld_state_t nxt;

    // output process: load strobes
    always_comb begin
        par_we = 1'b0;
        ser_we = 1'b0;
        unique case (state)
            LD_AE_LO, LD_AE_HI, LD_AF_LO, LD_AF_HI:
                par_we = ld && wr_en && !part_rst;
            LD_SERIAL:
                ser_we = ser_en && !part_rst;
            default: ;
        endcase
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (part_rst) begin
            nxt = (state == LD_SERIAL) ? LD_SERIAL : LD_AE_LO;
        end else begin
            unique case (state)
                LD_AE_LO:  if (par_we) nxt = LD_AE_HI;
                LD_AE_HI:  if (par_we) nxt = LD_AF_LO;
                LD_AF_LO:  if (par_we) nxt = LD_AF_HI;
                LD_AF_HI:  if (par_we) nxt = LD_AE_LO;
                LD_SERIAL: nxt = LD_SERIAL;
                default:   nxt = LD_AE_LO;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (mst_rst) state <= ser_mode_sel ? LD_SERIAL : LD_AE_LO;
        else         state <= nxt;
    end

    // serial bit position
    always_ff @(posedge clk) begin
        if (mst_rst || part_rst)
            ser_idx <= '0;
        else if (ser_we)
            ser_idx <= (ser_idx == IDX_W'(NBITS - 1)) ? '0 : ser_idx + 1'b1;
    end

    // R3
    par_wrap_chk: assert property (@(posedge clk) disable iff (mst_rst)
        (state == LD_AF_HI && par_we) |=> state == LD_AE_LO);

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (mst_rst)
        (state == LD_SERIAL) |=> state == LD_SERIAL);

    // R4
    ser_wrap_chk: assert property (@(posedge clk) disable iff (mst_rst)
        (ser_we && ser_idx == IDX_W'(NBITS - 1)) |=> ser_idx == '0);
endmodule

// File: rtl/pflag_regs.sv
module pflag_regs
    import pflag_pkg::*;
#(
    parameter int CNT_W = 14,
    parameter int BUS_W = 9,
    parameter logic [CNT_W-1:0] PRESET_LO = 'h07F,
    parameter logic [CNT_W-1:0] PRESET_HI = 'h3FF,
    localparam int HI_W  = CNT_W - BUS_W,
    localparam int IDX_W = $clog2(2 * CNT_W)
) (
    input  logic             clk,
    input  logic             mst_rst,
    input  logic             ld,
    input  ld_state_t        state,
    input  logic             par_we,
    input  logic             ser_we,
    input  logic [IDX_W-1:0] ser_idx,
    input  logic             ser_in,
    input  logic [BUS_W-1:0] wdata,
    output logic [CNT_W-1:0] ae_off,
    output logic [CNT_W-1:0] af_off
);
    logic [CNT_W-1:0] ae_nxt, af_nxt;

    always_comb begin
        ae_nxt = ae_off;
        af_nxt = af_off;
        if (par_we) begin
            unique case (state)
                LD_AE_LO: ae_nxt[BUS_W-1:0]     = wdata;
                LD_AE_HI: ae_nxt[CNT_W-1:BUS_W] = wdata[HI_W-1:0];
                LD_AF_LO: af_nxt[BUS_W-1:0]     = wdata;
                LD_AF_HI: af_nxt[CNT_W-1:BUS_W] = wdata[HI_W-1:0];
                default: ;
            endcase
        end
        if (ser_we) begin
            for (int i = 0; i < CNT_W; i++) begin
                if (ser_idx == IDX_W'(i))         ae_nxt[i] = ser_in;
                if (ser_idx == IDX_W'(i + CNT_W)) af_nxt[i] = ser_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (mst_rst) begin
            ae_off <= ld ? PRESET_HI : PRESET_LO;
            af_off <= ld ? PRESET_HI : PRESET_LO;
        end else begin
            ae_off <= ae_nxt;
            af_off <= af_nxt;
        end
    end

    // R6
    hold_offsets_chk: assert property (@(posedge clk) disable iff (mst_rst)
        (!par_we && !ser_we) |=> ($stable(ae_off) && $stable(af_off)));
endmodule

// File: rtl/pflag_cmp.sv
module pflag_cmp #(
    parameter int CNT_W = 14,
    localparam logic [CNT_W:0] DEPTH = (CNT_W + 1)'(1) << CNT_W
) (
    input  logic           clk,
    input  logic           mst_rst,
    input  logic [CNT_W:0] fill_cnt,
    input  logic [CNT_W-1:0] ae_off,
    input  logic [CNT_W-1:0] af_off,
    output logic           almost_empty,
    output logic           almost_full
);
    logic [CNT_W:0] free_cnt;
    assign free_cnt = DEPTH - fill_cnt;

    always_ff @(posedge clk) begin
        if (mst_rst) begin
            almost_empty <= 1'b1;
            almost_full  <= 1'b0;
        end else begin
            almost_empty <= fill_cnt <= {1'b0, ae_off};
            almost_full  <= free_cnt <= {1'b0, af_off};
        end
    end

    // R7
    empty_flag_chk: assert property (@(posedge clk) disable iff (mst_rst)
        (fill_cnt == '0) |=> almost_empty);

    // R8
    full_flag_chk: assert property (@(posedge clk) disable iff (mst_rst)
        (fill_cnt == DEPTH) |=> almost_full);
endmodule

// File: rtl/pflag_unit.sv
module pflag_unit
    import pflag_pkg::*;
#(
    parameter int CNT_W = 14,
    parameter int BUS_W = 9,
    parameter logic [CNT_W-1:0] PRESET_LO = 'h07F,
    parameter logic [CNT_W-1:0] PRESET_HI = 'h3FF,
    localparam int IDX_W = $clog2(2 * CNT_W)
) (
    input  logic             clk,
    input  logic             mst_rst,
    input  logic             part_rst,
    input  logic             ser_mode_sel,
    input  logic             ld,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wdata,
    input  logic             ser_en,
    input  logic             ser_in,
    input  logic [CNT_W:0]   fill_cnt,
    output logic             almost_empty,
    output logic             almost_full,
    output logic             push_ok
);
    ld_state_t        state;
    logic             par_we, ser_we;
    logic [IDX_W-1:0] ser_idx;
    logic [CNT_W-1:0] ae_off, af_off;

    pflag_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .mst_rst(mst_rst), .part_rst(part_rst),
        .ser_mode_sel(ser_mode_sel), .ld(ld), .wr_en(wr_en), .ser_en(ser_en),
        .state(state), .par_we(par_we), .ser_we(ser_we), .ser_idx(ser_idx)
    );

    pflag_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W),
                 .PRESET_LO(PRESET_LO), .PRESET_HI(PRESET_HI)) u_regs (
        .clk(clk), .mst_rst(mst_rst), .ld(ld), .state(state),
        .par_we(par_we), .ser_we(ser_we), .ser_idx(ser_idx),
        .ser_in(ser_in), .wdata(wdata), .ae_off(ae_off), .af_off(af_off)
    );

    pflag_cmp #(.CNT_W(CNT_W)) u_cmp (
        .clk(clk), .mst_rst(mst_rst), .fill_cnt(fill_cnt),
        .ae_off(ae_off), .af_off(af_off),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    assign push_ok = wr_en && !ld && !ser_en;
endmodule

// File: tb/sim_pflag_unit.sv
module sim_pflag_unit;
    localparam int DEPTH = 16384;

    logic       clk = 1'b0;
    logic       mst_rst = 1'b1, part_rst = 1'b0, ser_mode_sel = 1'b0;
    logic       ld = 1'b0, wr_en = 1'b0, ser_en = 1'b0, ser_in = 1'b0;
    logic [8:0] wdata = '0;
    logic [14:0] fill_cnt = 15'(DEPTH);
    logic       almost_empty, almost_full, push_ok;

    int total = 0, bad = 0;
    bit running = 1'b0;

    pflag_unit u0 (
        .clk(clk), .mst_rst(mst_rst), .part_rst(part_rst),
        .ser_mode_sel(ser_mode_sel), .ld(ld), .wr_en(wr_en), .wdata(wdata),
        .ser_en(ser_en), .ser_in(ser_in), .fill_cnt(fill_cnt),
        .almost_empty(almost_empty), .almost_full(almost_full), .push_ok(push_ok)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    int m_ao, m_fo, m_step, m_bit;
    bit m_ser, m_ae, m_af;
    always @(posedge clk) begin
        if (mst_rst) begin
            m_ae = 1; m_af = 0; m_ser = ser_mode_sel;
            m_ao = ld ? 'h3FF : 'h7F; m_fo = m_ao; m_step = 0; m_bit = 0;
        end else begin
            m_ae = (int'(fill_cnt) <= m_ao);
            m_af = ((DEPTH - int'(fill_cnt)) <= m_fo);
            if (part_rst) begin
                m_step = 0; m_bit = 0;
            end else if (!m_ser && ld && wr_en) begin
                case (m_step)
                    0: m_ao = (m_ao & ~'h1FF) | int'(wdata);
                    1: m_ao = (m_ao & 'h1FF) | ((int'(wdata) & 'h1F) << 9);
                    2: m_fo = (m_fo & ~'h1FF) | int'(wdata);
                    default: m_fo = (m_fo & 'h1FF) | ((int'(wdata) & 'h1F) << 9);
                endcase
                m_step = (m_step + 1) % 4;
            end else if (m_ser && ser_en) begin
                if (m_bit < 14) m_ao = (m_ao & ~(1 << m_bit)) | (int'(ser_in) << m_bit);
                else m_fo = (m_fo & ~(1 << (m_bit - 14))) | (int'(ser_in) << (m_bit - 14));
                m_bit = (m_bit + 1) % 28;
            end
        end
    end

    task automatic chk(input logic got, input logic exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%b expected=%b at %0t", tag, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #2;
        if (running) begin
            chk(almost_empty, m_ae, "R7 model almost_empty");
            chk(almost_full, m_af, "R8 model almost_full");
            chk(push_ok, wr_en && !ld && !ser_en, "R9 model push_ok");
        end
    end

    task automatic probe(input int f, input logic e_ae, input logic e_af, input string tag);
        @(negedge clk) fill_cnt = 15'(f);
        @(posedge clk); #3;
        chk(almost_empty, e_ae, {tag, " ae"});
        chk(almost_full, e_af, {tag, " af"});
    endtask

    task automatic pwrite(input int v);
        @(negedge clk) begin ld = 1; wr_en = 1; wdata = 9'(v); end
        @(negedge clk) begin ld = 0; wr_en = 0; end
    endtask

    task automatic sshift(input int ae, input int af);
        for (int i = 0; i < 28; i++) begin
            @(negedge clk) begin
                ser_en = 1;
                ser_in = (i < 14) ? ae[i] : af[i - 14];
            end
        end
        @(negedge clk) ser_en = 0;
    endtask

    initial begin
        #(200000 * 10);
        total++; bad++;
        $display("FAIL watchdog: got=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R10: reset flags with full FIFO presented
        repeat (2) @(posedge clk);
        #3;
        chk(almost_empty, 1'b1, "R10 reset ae");
        chk(almost_full, 1'b0, "R10 reset af");
        running = 1;
        @(negedge clk) mst_rst = 0;
        // R1: low preset 0x07F
        probe('h7F, 1, 0, "R1 lo preset edge");
        probe('h80, 0, 0, "R1 lo preset above");
        probe(DEPTH - 'h7F, 0, 1, "R1 lo preset full edge");
        probe(DEPTH - 'h80, 0, 0, "R1 lo preset full below");
        // R9: plain write passes
        @(negedge clk) wr_en = 1;
        @(posedge clk); #3; chk(push_ok, 1'b1, "R9 plain write");
        @(negedge clk) wr_en = 0;
        // R3: parallel load ae=0x0A5 af=0x1234
        pwrite('h0A5); pwrite(0); pwrite('h034); pwrite('h09);
        probe('hA5, 1, 0, "R3 ae edge");
        probe('hA6, 0, 0, "R3 ae above");
        probe(11724, 0, 1, "R3 af edge");
        probe(11723, 0, 0, "R3 af below");
        // R5: serial pins ignored in parallel mode
        sshift('h3FFF, 'h3FFF);
        probe('hA6, 0, 0, "R5 ser ignored ae");
        probe(11723, 0, 0, "R5 ser ignored af");
        // R6: partial reset mid-sequence
        pwrite('h011); pwrite(0);
        @(negedge clk) part_rst = 1;
        @(negedge clk) part_rst = 0;
        probe('h11, 1, 0, "R6 offsets kept");
        probe('h12, 0, 0, "R6 offsets kept above");
        pwrite('h022);
        probe('h22, 1, 0, "R6 sequence restarted");
        probe('h23, 0, 0, "R6 sequence restarted above");
        probe(11724, 0, 1, "R6 af untouched");
        // R1/R2: master reset, high preset, serial mode
        @(negedge clk) begin mst_rst = 1; ld = 1; ser_mode_sel = 1; end
        repeat (2) @(negedge clk);
        mst_rst = 0; ld = 0; ser_mode_sel = 0;
        probe('h3FF, 1, 0, "R1 hi preset edge");
        probe('h400, 0, 0, "R1 hi preset above");
        probe(DEPTH - 'h3FF, 0, 1, "R1 hi preset full edge");
        // R5: parallel writes ignored in serial mode
        pwrite('h001); pwrite(0);
        probe('h400, 0, 0, "R5 par ignored");
        probe('h3FF, 1, 0, "R2 serial mode kept");
        // R4: serial load ae=5 af=0x100
        sshift('h005, 'h100);
        probe(5, 1, 0, "R4 ae edge");
        probe(6, 0, 0, "R4 ae above");
        probe(DEPTH - 'h100, 0, 1, "R4 af edge");
        probe(DEPTH - 'h101, 0, 0, "R4 af below");
        // R6: partial reset in serial mode keeps mode, restarts bits
        sshift('h007, 'h100);
        @(negedge clk) ser_en = 1;
        ser_in = 1;
        @(negedge clk) begin ser_en = 0; part_rst = 1; end
        @(negedge clk) part_rst = 0;
        sshift('h009, 'h200);
        probe(9, 1, 0, "R6 serial restart ae");
        probe(10, 0, 0, "R6 serial restart above");
        probe(DEPTH - 'h200, 0, 1, "R6 serial restart af");
        // sweep against the model
        for (int i = 0; i < 300; i++) begin
            @(negedge clk) begin
                fill_cnt = 15'((i * 97) % (DEPTH + 1));
                wr_en = i[0]; ser_en = i[2] & i[3]; ser_in = i[1];
            end
        end
        @(negedge clk) begin wr_en = 0; ser_en = 0; end
        repeat (2) @(posedge clk);
        #4;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule